// File: doc/BRIEF.md
# Variable-Page-Size Translation Tag Array

This block is a small fully associative address-translation buffer. Each entry maps a virtual page onto a real page, and each page can have its own size, from 1 KB up to 256 MB. The page sizes are powers of four. An entry holds a 22-bit virtual page tag, a valid bit, an address-space bit, a 4-bit size code, an 8-bit owner ID, four hardware-made parity bits over the tag word, a 22-bit real page tag and a few extra upper real-address bits.

Software fills an entry one 32-bit word at a time, using an entry index and a word select. The owner ID does not go through the data word. It travels on a side input when word 0 is written, and it comes back on a side output when word 0 is read.

A translation request presents a 32-bit virtual address, an address-space bit and a process ID. The same port serves a software search: the search flag makes the comparison use a separate search-space input in place of the request's space bit. One cycle after the request, the block returns a hit flag, the index of the winning entry, the real address, a flag for more than one match and a parity-error flag.

Top module: `vps_tlb`

## Requirements
- R1: After reset, every entry is invalid and all of its fields read as zero. No request hits, and out_valid is 0.
- R2: The word layout is fixed. Word 0 holds the virtual page tag in [31:10], valid in [9], space in [8], size code in [7:4] and parity in [3:0]. The owner ID is written from sw_tid_in and read on sw_tid_out, together with word 0. Word 1 holds the real page tag in [31:10] and reads 0 in [9:0]. Word 2 holds the upper real bits in [3:0] and reads 0 elsewhere. Writes to word 3 change nothing, and word 3 reads 0. Read data appears on sw_rdata the cycle after the read.
- R3: Parity bit k is the XOR of word-0 bits [4+7k+6 : 4+7k], for k = 0..3, so that each group has even parity. The hardware computes it on every word-0 write, and the parity bits supplied with the write are ignored.
- R4: For a size code s, the page size is 4^s KB, and only EA[31:10+2s] is compared with the matching tag bits. The legal codes are 0, 1, 2, 3, 4, 5, 7 and 9. An entry with any other code never matches.
- R5: Only entries whose valid bit is 1 can match. Writing word 0 with bit 9 clear removes the entry from all later comparisons.
- R6: The entry's space bit must equal lk_as when lk_search is 0, and must equal srch_space when lk_search is 1.
- R7: An owner ID of zero matches any process ID. A nonzero ID matches only when it equals lk_pid.
- R8: On a hit, out_ra is built from three parts. The upper real bits go in [35:32]. The real page tag supplies the bits above the page offset. EA supplies the offset bits. On a miss, out_ra is 0.
- R9: If several entries match, the lowest index is reported and out_multi is 1. With a single match, out_multi is 0.
- R10: Results are registered. out_valid and the other results appear exactly one cycle after lk_req. A write in the same cycle as a request is seen only by later requests.
- R11: out_perr is 1 only on a hit whose entry's stored parity differs from the parity recomputed over the stored tag word. Entries written through the port never raise it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_en | input | 1 | Software word access strobe |
| sw_we | input | 1 | 1 = write, 0 = read |
| sw_idx | input | 4 | Entry index |
| sw_word | input | 2 | Word select |
| sw_wdata | input | 32 | Write data word |
| sw_tid_in | input | 8 | Owner ID written with word 0 |
| sw_rdata | output | 32 | Registered read data |
| sw_tid_out | output | 8 | Owner ID read with word 0 |
| lk_req | input | 1 | Translation or search request |
| lk_search | input | 1 | 1 = software search (uses srch_space) |
| lk_ea | input | 32 | Virtual address |
| lk_as | input | 1 | Address-space bit for translations |
| srch_space | input | 1 | Address-space bit for searches |
| lk_pid | input | 8 | Process ID |
| out_valid | output | 1 | Result valid, one cycle after lk_req |
| out_hit | output | 1 | Some entry matched |
| out_idx | output | 4 | Index of the winning entry |
| out_ra | output | 36 | Real address |
| out_multi | output | 1 | More than one entry matched |
| out_perr | output | 1 | Tag parity error on the winning entry |

## Verification
A bad stored tag or size code shows up as a wrong hit, a wrong index or a shifted offset boundary in out_ra. Because results are registered, it appears on the first request after the faulty write. A parity unit that computes wrongly shows up at once in the word-0 readback, and through out_perr on the next hit to that entry. The priority logic and the space and owner-ID gating are checked with overlapping pages, with both space selections, and with global and private IDs. A mistake there changes out_idx, out_multi or out_hit in the cycle after the request.

// File: rtl/vps_tlb_pkg.sv
package vps_tlb_pkg;
  localparam int EA_W    = 32;
  localparam int OFS_MIN = 10;
  localparam int EPN_W   = EA_W - OFS_MIN;
  localparam int SZ_W    = 4;
  localparam int PAR_N   = 4;
  localparam int TAG_W   = EPN_W + 2 + SZ_W;
  localparam int GRP_W   = TAG_W / PAR_N;

  function automatic logic size_ok(logic [SZ_W-1:0] sz);
    case (sz)
      4'd0, 4'd1, 4'd2, 4'd3, 4'd4, 4'd5, 4'd7, 4'd9: size_ok = 1'b1;
      default: size_ok = 1'b0;
    endcase
  endfunction

  function automatic logic [EPN_W-1:0] cmp_mask(logic [SZ_W-1:0] sz);
    for (int i = 0; i < EPN_W; i++)
      cmp_mask[i] = (i >= 2 * int'(sz));
  endfunction

  function automatic logic [PAR_N-1:0] tag_par(logic [TAG_W-1:0] t);
    for (int k = 0; k < PAR_N; k++)
      tag_par[k] = ^t[k*GRP_W +: GRP_W];
  endfunction
endpackage

// File: rtl/vps_tlb_entry.sv
module vps_tlb_entry
  import vps_tlb_pkg::*;
#(
  parameter int TID_W  = 8,
  parameter int ERPN_W = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_en,
  input  logic [1:0]             wr_word,
  input  logic [31:0]            wr_data,
  input  logic [TID_W-1:0]       wr_tid,
  output logic [31:0]            rd_data [4],
  output logic [TID_W-1:0]       rd_tid,
  input  logic [EA_W-1:0]        lk_ea,
  input  logic                   lk_space,
  input  logic [TID_W-1:0]       lk_pid,
  output logic                   match,
  output logic                   par_bad,
  output logic [ERPN_W+EA_W-1:0] ra
);
  logic [EPN_W-1:0]  epn, rpn, msk;
  logic              vld, spc;
  logic [SZ_W-1:0]   sz;
  logic [PAR_N-1:0]  par;
  logic [TID_W-1:0]  tid;
  logic [ERPN_W-1:0] erpn;

  always_ff @(posedge clk) begin
    if (rst) begin
      epn <= '0; rpn <= '0; vld <= 1'b0; spc <= 1'b0;
      sz <= '0; par <= '0; tid <= '0; erpn <= '0;
    end else if (wr_en) begin
      case (wr_word)
        2'd0: begin
          epn <= wr_data[31:OFS_MIN];
          vld <= wr_data[9];
          spc <= wr_data[8];
          sz  <= wr_data[7:4];
          par <= tag_par(wr_data[31:4]);
          tid <= wr_tid;
        end
        2'd1: rpn  <= wr_data[31:OFS_MIN];
        2'd2: erpn <= wr_data[ERPN_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_data[0] = {epn, vld, spc, sz, par};
    rd_data[1] = {rpn, {OFS_MIN{1'b0}}};
    rd_data[2] = 32'(erpn);
    rd_data[3] = '0;
  end
  assign rd_tid = tid;

  assign msk     = cmp_mask(sz);
  assign match   = vld && size_ok(sz) && (spc == lk_space) &&
                   ((tid == '0) || (tid == lk_pid)) &&
                   (((epn ^ lk_ea[EA_W-1:OFS_MIN]) & msk) == '0);
  assign par_bad = (tag_par({epn, vld, spc, sz}) != par);
  assign ra      = {erpn, (rpn & msk) | (lk_ea[EA_W-1:OFS_MIN] & ~msk),
                    lk_ea[OFS_MIN-1:0]};

  // R5
  clear_valid_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_word == 2'd0 && !wr_data[9]) |=> !match);
  // R3
  par_store_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_word == 2'd0) |=> !par_bad);
endmodule

// File: rtl/vps_tlb_pick.sv
module vps_tlb_pick #(
  parameter int N  = 16,
  parameter int IW = 4
) (
  input  logic [N-1:0]  hits,
  output logic          any,
  output logic          multi,
  output logic [IW-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--)
      if (hits[i]) idx = IW'(i);
  end
  assign any   = |hits;
  assign multi = (hits & (hits - 1'b1)) != '0;
endmodule

// File: rtl/vps_tlb.sv
module vps_tlb
  import vps_tlb_pkg::*;
#(
  parameter int N_ENT  = 16,
  parameter int TID_W  = 8,
  parameter int ERPN_W = 4,
  localparam int IDX_W = $clog2(N_ENT),
  localparam int RA_W  = ERPN_W + EA_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sw_en,
  input  logic             sw_we,
  input  logic [IDX_W-1:0] sw_idx,
  input  logic [1:0]       sw_word,
  input  logic [31:0]      sw_wdata,
  input  logic [TID_W-1:0] sw_tid_in,
  output logic [31:0]      sw_rdata,
  output logic [TID_W-1:0] sw_tid_out,
  input  logic             lk_req,
  input  logic             lk_search,
  input  logic [EA_W-1:0]  lk_ea,
  input  logic             lk_as,
  input  logic             srch_space,
  input  logic [TID_W-1:0] lk_pid,
  output logic             out_valid,
  output logic             out_hit,
  output logic [IDX_W-1:0] out_idx,
  output logic [RA_W-1:0]  out_ra,
  output logic             out_multi,
  output logic             out_perr
);
  logic             space;
  logic [N_ENT-1:0] hit_vec, pb_vec;
  logic [RA_W-1:0]  ra_arr  [N_ENT];
  logic [31:0]      rd_arr  [N_ENT][4];
  logic [TID_W-1:0] tid_arr [N_ENT];
  logic             any, multi;
  logic [IDX_W-1:0] pidx;

  assign space = lk_search ? srch_space : lk_as;

  for (genvar g = 0; g < N_ENT; g++) begin : g_ent
    vps_tlb_entry #(.TID_W(TID_W), .ERPN_W(ERPN_W)) u_ent (
      .clk(clk), .rst(rst),
      .wr_en(sw_en && sw_we && (sw_idx == IDX_W'(g))),
      .wr_word(sw_word), .wr_data(sw_wdata), .wr_tid(sw_tid_in),
      .rd_data(rd_arr[g]), .rd_tid(tid_arr[g]),
      .lk_ea(lk_ea), .lk_space(space), .lk_pid(lk_pid),
      .match(hit_vec[g]), .par_bad(pb_vec[g]), .ra(ra_arr[g])
    );
  end

  vps_tlb_pick #(.N(N_ENT), .IW(IDX_W)) u_pick (
    .hits(hit_vec), .any(any), .multi(multi), .idx(pidx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0; out_hit <= 1'b0; out_idx <= '0; out_ra <= '0;
      out_multi <= 1'b0; out_perr <= 1'b0; sw_rdata <= '0; sw_tid_out <= '0;
    end else begin
      out_valid <= lk_req;
      if (lk_req) begin
        out_hit   <= any;
        out_idx   <= pidx;
        out_ra    <= any ? ra_arr[pidx] : '0;
        out_multi <= multi;
        out_perr  <= any && pb_vec[pidx];
      end else begin
        out_hit   <= 1'b0;
        out_multi <= 1'b0;
        out_perr  <= 1'b0;
      end
      if (sw_en && !sw_we) begin
        sw_rdata   <= rd_arr[sw_idx][sw_word];
        sw_tid_out <= tid_arr[sw_idx];
      end
    end
  end

  // R10
  out_valid_chk: assert property (@(posedge clk) disable iff (rst)
    lk_req |=> out_valid);
  // R9
  multi_hit_chk: assert property (@(posedge clk) disable iff (rst)
    out_multi |-> out_hit);
  // R11
  perr_hit_chk: assert property (@(posedge clk) disable iff (rst)
    out_perr |-> out_hit);
endmodule

// File: tb/tb_vps_tlb.sv
module tb_vps_tlb;
  localparam int CLK_P = 10;
  localparam int NV = 15;

  logic        clk = 1'b0, rst = 1'b1;
  logic        sw_en = 0, sw_we = 0;
  logic [3:0]  sw_idx = 0;
  logic [1:0]  sw_word = 0;
  logic [31:0] sw_wdata = 0;
  logic [7:0]  sw_tid_in = 0;
  logic [31:0] sw_rdata;
  logic [7:0]  sw_tid_out;
  logic        lk_req = 0, lk_search = 0, lk_as = 0, srch_space = 0;
  logic [31:0] lk_ea = 0;
  logic [7:0]  lk_pid = 0;
  logic        out_valid, out_hit, out_multi, out_perr;
  logic [3:0]  out_idx;
  logic [35:0] out_ra;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  vps_tlb dut (.*);

  // row: ea, as, pid, search, srch_space, hit, idx, multi, ra
  localparam logic [84:0] VEC [NV] = '{
    {32'h1000_0123, 1'b0, 8'h03, 1'b0, 1'b0, 1'b1, 4'd0, 1'b1, 36'h1_2000_0123},
    {32'h1001_0ABC, 1'b0, 8'h03, 1'b0, 1'b0, 1'b1, 4'd4, 1'b0, 36'h0_8001_0ABC},
    {32'h3000_05FF, 1'b1, 8'h07, 1'b0, 1'b0, 1'b1, 4'd1, 1'b0, 36'h0_4000_09FF},
    {32'h3000_05FF, 1'b1, 8'h08, 1'b0, 1'b0, 1'b0, 4'd0, 1'b0, 36'h0},
    {32'h3000_05FF, 1'b0, 8'h07, 1'b0, 1'b0, 1'b0, 4'd0, 1'b0, 36'h0},
    {32'h3000_0800, 1'b1, 8'h07, 1'b0, 1'b0, 1'b0, 4'd0, 1'b0, 36'h0},
    {32'h5ABC_DEF0, 1'b0, 8'h33, 1'b0, 1'b0, 1'b1, 4'd2, 1'b0, 36'h2_6ABC_DEF0},
    {32'h5ABC_DEF0, 1'b1, 8'h33, 1'b0, 1'b0, 1'b0, 4'd0, 1'b0, 36'h0},
    {32'h7000_0000, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 4'd0, 1'b0, 36'h0},
    {32'h9000_0000, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 4'd0, 1'b0, 36'h0},
    {32'hA0FF_FFFF, 1'b0, 8'h09, 1'b0, 1'b0, 1'b1, 4'd6, 1'b0, 36'h0_B0FF_FFFF},
    {32'hA100_0000, 1'b0, 8'h09, 1'b0, 1'b0, 1'b0, 4'd0, 1'b0, 36'h0},
    {32'hC000_FFFF, 1'b1, 8'h42, 1'b0, 1'b0, 1'b1, 4'd7, 1'b0, 36'h3_D000_FFFF},
    {32'hC000_1234, 1'b0, 8'h42, 1'b1, 1'b1, 1'b1, 4'd7, 1'b0, 36'h3_D000_1234},
    {32'hC000_1234, 1'b1, 8'h42, 1'b1, 1'b0, 1'b0, 4'd0, 1'b0, 36'h0}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_par(input logic [31:0] w);
    for (int k = 0; k < 4; k++) exp_par[k] = ^w[4 + 7*k +: 7];
  endfunction

  task automatic sw_write(input int idx, input int wd, input logic [31:0] d, input logic [7:0] t);
    @(negedge clk);
    sw_en = 1; sw_we = 1; sw_idx = 4'(idx); sw_word = 2'(wd); sw_wdata = d; sw_tid_in = t;
    @(negedge clk);
    sw_en = 0; sw_we = 0;
  endtask

  task automatic sw_read(input int idx, input int wd, output logic [31:0] d, output logic [7:0] t);
    @(negedge clk);
    sw_en = 1; sw_we = 0; sw_idx = 4'(idx); sw_word = 2'(wd);
    @(negedge clk);
    sw_en = 0;
    d = sw_rdata; t = sw_tid_out;
  endtask

  task automatic lookup(input logic [31:0] ea, input logic as_b, input logic [7:0] pid,
                        input logic srch, input logic sspc);
    @(negedge clk);
    lk_req = 1; lk_ea = ea; lk_as = as_b; lk_pid = pid; lk_search = srch; srch_space = sspc;
    @(negedge clk);
    lk_req = 0;
  endtask

  task automatic put_entry(input int idx, input logic [31:0] base, input logic v, input logic ts,
                           input logic [3:0] sz, input logic [7:0] tid,
                           input logic [31:0] rbase, input logic [3:0] erpn);
    sw_write(idx, 0, {base[31:10], v, ts, sz, 4'hA}, tid);
    sw_write(idx, 1, {rbase[31:10], 10'h3FF}, 8'h00);
    sw_write(idx, 2, {28'h0, erpn}, 8'h00);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [7:0]  t;
    logic [31:0] w0;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1: reset state
    chk("R1 out_valid", 64'(out_valid), 64'd0);
    lookup(32'h0000_0000, 1'b0, 8'h00, 1'b0, 1'b0);
    chk("R1 miss after reset", 64'({out_valid, out_hit}), 64'b10);
    sw_read(3, 0, d, t);
    chk("R1 word0 zero", 64'({d, t}), 64'd0);

    put_entry(0, 32'h1000_0000, 1, 0, 4'd1, 8'd0, 32'h2000_0000, 4'd1);
    put_entry(1, 32'h3000_0400, 1, 1, 4'd0, 8'd7, 32'h4000_0800, 4'd0);
    put_entry(2, 32'h5000_0000, 1, 0, 4'd9, 8'd0, 32'h6000_0000, 4'd2);
    put_entry(3, 32'h7000_0000, 1, 0, 4'd6, 8'd0, 32'h7000_0000, 4'd0);
    put_entry(4, 32'h1000_0000, 1, 0, 4'd5, 8'd0, 32'h8000_0000, 4'd0);
    put_entry(5, 32'h9000_0000, 0, 0, 4'd4, 8'd0, 32'hE000_0000, 4'd0);
    put_entry(6, 32'hA000_0000, 1, 0, 4'd7, 8'd9, 32'hB000_0000, 4'd0);
    put_entry(7, 32'hC000_0000, 1, 1, 4'd3, 8'd0, 32'hD000_0000, 4'd3);

    // R4 R5 R6 R7 R8 R9 R11: table of lookups
    for (int i = 0; i < NV; i++) begin
      lookup(VEC[i][84:53], VEC[i][52], VEC[i][51:44], VEC[i][43], VEC[i][42]);
      chk($sformatf("R4-vec%0d hit/idx/multi", i),
          64'({out_valid, out_hit, out_idx, out_multi}),
          64'({1'b1, VEC[i][41], VEC[i][40:37], VEC[i][36]}));
      chk($sformatf("R8 vec%0d ra", i), 64'(out_ra), 64'(VEC[i][35:0]));
      chk($sformatf("R11 vec%0d perr", i), 64'(out_perr), 64'd0);
    end

    // R2 R3: readback, supplied parity ignored
    sw_read(1, 0, d, t);
    w0 = {22'h0C0001, 1'b1, 1'b1, 4'd0, 4'h0};
    w0[3:0] = exp_par(w0);
    chk("R3 word0 parity", 64'(d), 64'(w0));
    chk("R2 tid readback", 64'(t), 64'd7);
    sw_read(1, 1, d, t);
    chk("R2 word1", 64'(d), 64'h4000_0800);
    sw_read(2, 2, d, t);
    chk("R2 word2", 64'(d), 64'd2);
    sw_write(2, 3, 32'hFFFF_FFFF, 8'hFF);
    sw_read(2, 3, d, t);
    chk("R2 word3 reads zero", 64'(d), 64'd0);
    sw_read(2, 0, d, t);
    w0 = {22'h140000, 1'b1, 1'b0, 4'd9, 4'h0};
    w0[3:0] = exp_par(w0);
    chk("R2 word0 untouched by word3 write", 64'({d, t}), 64'({w0, 8'h00}));

    // R10: write in same cycle as lookup not seen
    @(negedge clk);
    sw_en = 1; sw_we = 1; sw_idx = 4'd5; sw_word = 2'd0;
    sw_wdata = {22'h240000, 1'b1, 1'b0, 4'd4, 4'h0}; sw_tid_in = 8'd0;
    lk_req = 1; lk_ea = 32'h9000_0010; lk_as = 0; lk_pid = 8'h11; lk_search = 0;
    @(negedge clk);
    sw_en = 0; sw_we = 0; lk_req = 0;
    chk("R10 same-cycle write unseen", 64'({out_valid, out_hit}), 64'b10);
    @(negedge clk);
    chk("R10 no request, out_valid low", 64'(out_valid), 64'd0);
    lookup(32'h9000_0010, 1'b0, 8'h11, 1'b0, 1'b0);
    chk("R10 later lookup hits", 64'({out_hit, out_idx, out_ra}), 64'({1'b1, 4'd5, 36'h0_E000_0010}));

    // R5: clearing valid removes entry
    sw_write(6, 0, {22'h280000, 1'b0, 1'b0, 4'd7, 4'h0}, 8'd9);
    lookup(32'hA0FF_FFFF, 1'b0, 8'h09, 1'b0, 1'b0);
    chk("R5 cleared entry misses", 64'(out_hit), 64'd0);

    // R9: remove entry 0, overlap gone
    sw_write(0, 0, {22'h040000, 1'b0, 1'b0, 4'd1, 4'h0}, 8'd0);
    lookup(32'h1000_0123, 1'b0, 8'h03, 1'b0, 1'b0);
    chk("R9 single match", 64'({out_hit, out_idx, out_multi}), 64'({1'b1, 4'd4, 1'b0}));

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule